// File: doc/BRIEF.md
# Two-Channel Low-Side Switch Channel Controller

This block decides, for each of two power channels, whether the gate driver is enabled. It first picks a command for each channel from one of four sources: the parallel pin, the serial on/off bit, the OR of the two, or the AND of the two. It then applies protection. An overtemperature flag cuts the channel at once. Recovery from overtemperature is either automatic once the flag clears or latched until the command rises again. An over-current flag is handled in one of two ways, chosen per channel. In the limiting mode the channel stays on and a fault is raised once the flag has lasted past a filter time. In the switch-off mode the channel is cut and held off once the flag has lasted past a shutoff delay.

The comparator flags arrive already synchronous to the system clock. Both time windows are counted in clock cycles. Each channel has its own pair of counters, and a counter restarts whenever its flag drops. A sleep input forces both channels off and clears every protection latch. The slew-rate selection is passed straight through to the driver.

Top module: `lsw_chan_ctrl`

## Requirements
- R1: The 2-bit source field sets each channel's command: 00 = parallel pin only, 01 = pin OR serial bit, 10 = pin AND serial bit, 11 = serial bit only. All inputs are active high. With no protection active, `gate_en[n]` equals the command in the same cycle.
- R2: The serial bit of one channel affects only that channel's gate enable.
- R3: While a channel is commanded on, a high overtemperature flag drives its `gate_en` low in the same cycle, with no delay.
- R4: When `ot_latch_mode` = 0, the channel turns back on in the same cycle that its overtemperature flag clears, provided its command is still high.
- R5: When `ot_latch_mode` = 1, a channel that was cut by overtemperature stays off after the flag clears. It turns on again only in the cycle in which its command makes a new low-to-high transition.
- R6: When `ilim_mode[n]` = 0 and the channel is on, an over-current flag held for SHUTOFF_CYC clock edges leaves the gate on. On edge SHUTOFF_CYC+1 the gate is cut and latched off. The latch clears only on a new low-to-high transition of the command.
- R7: When `ilim_mode[n]` = 1, over-current never cuts the gate. `ovl_fault[n]` goes high after edge FILTER_CYC+1 of a continuous flag, and falls one edge after the flag drops.
- R8: Both over-current windows restart from zero whenever the flag drops. A flag held for SHUTOFF_CYC edges, dropped, and then raised again for SHUTOFF_CYC edges never cuts the gate.
- R9: `ilim_mode[n]` may change while the channel runs. Switching to 1 releases an overload shutoff at the next edge. Switching to 0 starts a fresh shutoff window.
- R10: While `sleep` is high both gate enables are low. Sleep clears all overtemperature and overload latches, so after wake a held-high command drives the gate without a new transition.
- R11: `slew_out` equals `slew_sel` at all times.
- R12: During and after reset, with all inputs low, `gate_en` = 00 and `ovl_fault` = 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_in | input | NCH | Parallel command pin per channel |
| ser_on | input | NCH | Serial on/off bit per channel |
| src_mode | input | 2 | Command source select (00 pin, 01 OR, 10 AND, 11 serial) |
| ot_latch_mode | input | 1 | Overtemperature recovery: 0 auto-restart, 1 latch |
| ilim_mode | input | NCH | Overload reaction per channel: 0 timed switch-off, 1 limiting |
| slew_sel | input | NCH | Slew selection, passed through |
| sleep | input | 1 | Forces channels off and clears latches |
| ot_flag | input | NCH | Synchronous overtemperature flag per channel |
| oc_flag | input | NCH | Synchronous current-limit flag per channel |
| gate_en | output | NCH | Gate enable per channel |
| ovl_fault | output | NCH | Over-current fault in limiting mode |
| slew_out | output | NCH | Slew selection to the driver |

## Verification
The bench targets the window edges for both over-current modes. It checks the cycle just before and just after each expiry. A counter that is off by one would cut the gate, or raise the fault, one edge early or one edge late. It also checks a flag that drops one edge short of expiry and then returns, which catches a counter that fails to restart and cuts a healthy channel. It checks the rising-edge bypass of the overtemperature and overload latches, where a design without the bypass would lose a cycle of on-time. It checks the overload mode changing while a channel is latched, and wake from sleep with the command still high, which would stay dark if sleep left a latch set.

// File: rtl/lsw_pkg.sv
`timescale 1ns/1ps
// Shared types for the low-side channel controller.
package lsw_pkg;
    // Command source encoding; the values are decoded by the source mux.
    typedef enum logic [1:0] {
        SRC_PAR = 2'b00,
        SRC_OR  = 2'b01,
        SRC_AND = 2'b10,
        SRC_SER = 2'b11
    } src_sel_e;
endpackage

// File: rtl/lsw_src_mux.sv
`timescale 1ns/1ps
// Command source mux: builds each channel's command from the parallel pin
// and the serial bit according to the shared source field.
// Assumes all inputs are active high and synchronous to the system clock.
module lsw_src_mux #(
    parameter int NCH = 2
) (
    input  logic [1:0]     sel,
    input  logic [NCH-1:0] par,
    input  logic [NCH-1:0] ser,
    output logic [NCH-1:0] cmd
);
    import lsw_pkg::*;

    // Per-channel source selection.
    always_comb begin
        case (src_sel_e'(sel))
            SRC_PAR: cmd = par;
            SRC_OR:  cmd = par | ser;
            SRC_AND: cmd = par & ser;
            default: cmd = ser;
        endcase
    end
endmodule

// File: rtl/lsw_ovl_timer.sv
`timescale 1ns/1ps
// Saturating window counter. It counts clock edges while both the enable
// and the flag are high, and restarts at zero whenever either drops.
// 'expired' is high once the flag has lasted LIMIT edges and is still high.
// Assumes LIMIT >= 1.
module lsw_ovl_timer #(
    parameter int LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic flag,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM_W = W'(LIMIT);

    logic [W-1:0] cnt;

    // Count consecutive qualified cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!(en && flag)) begin
            cnt <= '0;
        end else if (cnt < LIM_W) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Window has run out while the condition is still present.
    assign expired = en && flag && (cnt == LIM_W);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM_W); // R8
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en && flag) |-> (cnt == '0)); // R8
endmodule

// File: rtl/lsw_ot_guard.sv
`timescale 1ns/1ps
// Overtemperature guard for one channel. The flag blocks the gate at once
// while the channel is commanded on. In latch mode a trip is remembered
// until the command rises again; the rising cycle itself is let through.
// Assumes 'rise' is the command's low-to-high transition from the channel.
module lsw_ot_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic latch_mode,
    input  logic cmd,
    input  logic rise,
    input  logic ot_flag,
    output logic ot_block
);
    logic ot_lat;

    // Remember an overtemperature trip in latch mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ot_lat <= 1'b0;
        end else if (sleep || !latch_mode) begin
            ot_lat <= 1'b0;
        end else if (cmd && ot_flag) begin
            ot_lat <= 1'b1;
        end else if (rise) begin
            ot_lat <= 1'b0;
        end
    end

    // Block the gate for a live flag or an unreleased latch.
    assign ot_block = (cmd && ot_flag) || (ot_lat && !rise);

    AST_LAT_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ot_lat |-> $past(latch_mode)); // R5
endmodule

// File: rtl/lsw_chan.sv
`timescale 1ns/1ps
// One power channel: detects command edges, applies the overtemperature
// guard and the two over-current reactions, and produces the gate enable
// and the limiting-mode fault.
// Assumes comparator flags are synchronous to clk.
module lsw_chan #(
    parameter int SHUTOFF_CYC = 20,
    parameter int FILTER_CYC  = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic cmd,
    input  logic latch_mode,
    input  logic ilim1,
    input  logic ot_flag,
    input  logic oc_flag,
    output logic gate,
    output logic fault
);
    logic cmd_q;
    logic rise;
    logic ot_block;
    logic ol_lat;
    logic shut_exp;
    logic filt_exp;

    // Previous command level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= 1'b0;
        else        cmd_q <= cmd;
    end

    assign rise = cmd && !cmd_q;

    lsw_ot_guard u_ot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .latch_mode (latch_mode),
        .cmd        (cmd),
        .rise       (rise),
        .ot_flag    (ot_flag),
        .ot_block   (ot_block)
    );

    // Gate enable: command qualified by all protection terms.
    assign gate = !sleep && cmd && !ot_block && !(ol_lat && !rise);

    lsw_ovl_timer #(.LIMIT(SHUTOFF_CYC)) u_shut (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (gate && !ilim1),
        .flag    (oc_flag),
        .expired (shut_exp)
    );

    lsw_ovl_timer #(.LIMIT(FILTER_CYC)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (gate && ilim1),
        .flag    (oc_flag),
        .expired (filt_exp)
    );

    // Overload switch-off latch, released by a command rise or limiting mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ol_lat <= 1'b0;
        end else if (sleep || ilim1) begin
            ol_lat <= 1'b0;
        end else if (shut_exp) begin
            ol_lat <= 1'b1;
        end else if (rise) begin
            ol_lat <= 1'b0;
        end
    end

    // Limiting-mode fault follows the filtered flag.
    always_ff @(posedge clk) begin
        if (!rst_n) fault <= 1'b0;
        else        fault <= filt_exp;
    end

    AST_OT_CUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |-> !gate); // R3
    AST_OT_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_mode && $past(latch_mode) && $past(ot_flag && cmd && !sleep)
         && cmd && !sleep) |-> !gate); // R5
    AST_SHUT_NEEDS_OVL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_lat) |-> $past(oc_flag && gate)); // R6
    AST_L1_NEVER_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim1 && $past(ilim1) && cmd && !sleep && !ot_block) |-> gate); // R7
    AST_FAULT_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(oc_flag && ilim1)); // R7
endmodule

// File: rtl/lsw_chan_ctrl.sv
`timescale 1ns/1ps
// Two-channel low-side switch controller top. Selects each channel's
// command source, runs one protection channel per output, and passes the
// slew selection through.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module lsw_chan_ctrl #(
    parameter int NCH         = 2,
    parameter int SHUTOFF_CYC = 20,
    parameter int FILTER_CYC  = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] par_in,
    input  logic [NCH-1:0] ser_on,
    input  logic [1:0]     src_mode,
    input  logic           ot_latch_mode,
    input  logic [NCH-1:0] ilim_mode,
    input  logic [NCH-1:0] slew_sel,
    input  logic           sleep,
    input  logic [NCH-1:0] ot_flag,
    input  logic [NCH-1:0] oc_flag,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] ovl_fault,
    output logic [NCH-1:0] slew_out
);
    logic [NCH-1:0] cmd;

    lsw_src_mux #(.NCH(NCH)) u_mux (
        .sel (src_mode),
        .par (par_in),
        .ser (ser_on),
        .cmd (cmd)
    );

    // One protection channel per output.
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lsw_chan #(
            .SHUTOFF_CYC (SHUTOFF_CYC),
            .FILTER_CYC  (FILTER_CYC)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .sleep      (sleep),
            .cmd        (cmd[i]),
            .latch_mode (ot_latch_mode),
            .ilim1      (ilim_mode[i]),
            .ot_flag    (ot_flag[i]),
            .oc_flag    (oc_flag[i]),
            .gate       (gate_en[i]),
            .fault      (ovl_fault[i])
        );
    end

    // Slew selection goes straight to the driver.
    assign slew_out = slew_sel;

    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (gate_en == '0)); // R10
    AST_AND_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (src_mode == 2'b10) |-> ((gate_en & ~(par_in & ser_on)) == '0)); // R1
    AST_SER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (src_mode == 2'b11) |-> ((gate_en & ~ser_on) == '0)); // R2
endmodule

// File: tb/sim_lsw_chan_ctrl.sv
`timescale 1ns/1ps
module sim_lsw_chan_ctrl;
    localparam int S = 20;
    localparam int F = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] par = '0, ser = '0, mode = '0, ilim = '0, slew = '0;
    logic [1:0] ot = '0, oc = '0;
    logic latm = 1'b0, slp = 1'b0;
    logic [1:0] gate, flt, slew_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lsw_chan_ctrl #(.NCH(2), .SHUTOFF_CYC(S), .FILTER_CYC(F)) u0 (
        .clk(clk), .rst_n(rst_n), .par_in(par), .ser_on(ser), .src_mode(mode),
        .ot_latch_mode(latm), .ilim_mode(ilim), .slew_sel(slew), .sleep(slp),
        .ot_flag(ot), .oc_flag(oc), .gate_en(gate), .ovl_fault(flt),
        .slew_out(slew_o)
    );

    // Reference model state built from the requirements.
    bit m_ot [2];
    bit m_ol [2];
    bit m_cq [2];
    bit m_flt [2];
    int m_sc [2];
    int m_fc [2];

    function automatic logic f_cmd(input logic [1:0] m, input logic p, input logic s);
        case (m)
            2'b00: return p;
            2'b01: return p | s;
            2'b10: return p & s;
            default: return s;
        endcase
    endfunction

    function automatic logic mdl_gate(input int ch);
        logic c, r;
        c = f_cmd(mode, par[ch], ser[ch]);
        r = c & !m_cq[ch];
        return !slp & c & !ot[ch] & !(m_ot[ch] & !r) & !(m_ol[ch] & !r);
    endfunction

    always @(posedge clk) begin
        for (int ch = 0; ch < 2; ch++) begin
            logic c, r, g, sh, fl;
            c = f_cmd(mode, par[ch], ser[ch]);
            r = c & !m_cq[ch];
            g = mdl_gate(ch);
            if (!rst_n) begin
                m_ot[ch] = 0; m_ol[ch] = 0; m_cq[ch] = 0; m_flt[ch] = 0;
                m_sc[ch] = 0; m_fc[ch] = 0;
            end else begin
                sh = g & !ilim[ch] & oc[ch] & (m_sc[ch] >= S);
                fl = g & ilim[ch] & oc[ch] & (m_fc[ch] >= F);
                m_sc[ch] = (g & !ilim[ch] & oc[ch]) ? ((m_sc[ch] < S) ? m_sc[ch] + 1 : m_sc[ch]) : 0;
                m_fc[ch] = (g & ilim[ch] & oc[ch]) ? ((m_fc[ch] < F) ? m_fc[ch] + 1 : m_fc[ch]) : 0;
                if (slp | !latm) m_ot[ch] = 0;
                else if (c & ot[ch]) m_ot[ch] = 1;
                else if (r) m_ot[ch] = 0;
                if (slp | ilim[ch]) m_ol[ch] = 0;
                else if (sh) m_ol[ch] = 1;
                else if (r) m_ol[ch] = 0;
                m_flt[ch] = fl;
                m_cq[ch] = c;
            end
        end
    end

    task automatic chk(input string tag, input string what, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, got, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seedv;
        seedv = $urandom(32'h1D5E);
        // R12: reset state
        repeat (3) nxt();
        #1 chk("R12", "gate in reset", gate, 2'b00);
        chk("R12", "fault in reset", flt, 2'b00);
        nxt(); rst_n = 1'b1;
        #1 chk("R12", "gate after reset", gate, 2'b00);

        // R1: all source encodings
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int s = 0; s < 2; s++) begin
                    logic e;
                    nxt();
                    mode = 2'(m); par = {1'b0, 1'(p)}; ser = {1'b0, 1'(s)};
                    case (m)
                        0: e = 1'(p);
                        1: e = 1'(p | s);
                        2: e = 1'(p & s);
                        default: e = 1'(s);
                    endcase
                    #1 chk("R1", "source mux", gate, {1'b0, e});
                end
            end
        end

        // R2: serial bits are per channel
        nxt(); mode = 2'b11; ser = 2'b01; par = 2'b10;
        #1 chk("R2", "serial ch0 only", gate, 2'b01);
        nxt(); ser = 2'b10; par = 2'b01;
        #1 chk("R2", "serial ch1 only", gate, 2'b10);

        // R11: slew pass-through
        slew = 2'b10; #1 chk("R11", "slew", slew_o, 2'b10);
        slew = 2'b01; #1 chk("R11", "slew", slew_o, 2'b01);

        // R3 / R4: immediate cut and auto restart
        nxt(); mode = 2'b00; par = 2'b11; ser = 2'b00;
        #1 chk("R1", "parallel both on", gate, 2'b11);
        nxt(); ot = 2'b01;
        #1 chk("R3", "ot immediate cut", gate, 2'b10);
        nxt(); #1 chk("R3", "ot held", gate, 2'b10);
        nxt(); ot = 2'b00;
        #1 chk("R4", "auto restart", gate, 2'b11);

        // R5: latch mode
        nxt(); latm = 1'b1;
        nxt(); ot = 2'b01;
        #1 chk("R3", "ot cut latch mode", gate, 2'b10);
        nxt(); ot = 2'b00;
        #1 chk("R5", "latched after flag clears", gate, 2'b10);
        repeat (5) nxt();
        #1 chk("R5", "still latched", gate, 2'b10);
        nxt(); par = 2'b10;
        nxt(); par = 2'b11;
        #1 chk("R5", "release on rise", gate, 2'b11);
        nxt(); #1 chk("R5", "released", gate, 2'b11);
        latm = 1'b0;

        // R6: timed switch-off window
        nxt(); ilim = 2'b00; oc = 2'b01;
        repeat (S) nxt();
        #1 chk("R6", "on at window end", gate, 2'b11);
        nxt(); #1 chk("R6", "cut after window", gate, 2'b10);
        oc = 2'b00;
        repeat (3) nxt();
        #1 chk("R6", "stays latched", gate, 2'b10);
        nxt(); par = 2'b10;
        nxt(); par = 2'b11;
        #1 chk("R6", "release on rise", gate, 2'b11);

        // R8: window restarts when flag drops
        nxt(); oc = 2'b01;
        repeat (S) nxt();
        oc = 2'b00;
        #1 chk("R8", "first burst", gate, 2'b11);
        nxt(); oc = 2'b01;
        repeat (S) nxt();
        #1 chk("R8", "second burst no cut", gate, 2'b11);
        oc = 2'b00;
        nxt(); #1 chk("R8", "after bursts", gate, 2'b11);

        // R7: limiting mode
        nxt(); ilim = 2'b01; oc = 2'b01;
        repeat (F) nxt();
        #1 chk("R7", "fault at filter end", flt, 2'b00);
        chk("R7", "gate in limiting", gate, 2'b11);
        nxt(); #1 chk("R7", "fault raised", flt, 2'b01);
        repeat (20) nxt();
        #1 chk("R7", "never cut", gate, 2'b11);
        nxt(); oc = 2'b00;
        #1 chk("R7", "fault holds one edge", flt, 2'b01);
        nxt(); #1 chk("R7", "fault drops", flt, 2'b00);

        // R9: mode change while running
        nxt(); ilim = 2'b00; oc = 2'b01;
        repeat (S + 1) nxt();
        #1 chk("R9", "tripped in switch-off mode", gate, 2'b10);
        nxt(); ilim = 2'b01;
        #1 chk("R9", "latch until edge", gate, 2'b10);
        nxt(); #1 chk("R9", "released by limiting mode", gate, 2'b11);
        nxt(); ilim = 2'b00;
        repeat (S) nxt();
        #1 chk("R9", "fresh window", gate, 2'b11);
        nxt(); #1 chk("R9", "fresh window expiry", gate, 2'b10);
        oc = 2'b00;
        nxt(); par = 2'b00;
        nxt(); par = 2'b11;

        // R10: sleep clears latches
        latm = 1'b1; oc = 2'b01; ot = 2'b10;
        repeat (S + 1) nxt();
        oc = 2'b00; ot = 2'b00;
        #1 chk("R10", "both latched before sleep", gate, 2'b00);
        nxt(); slp = 1'b1;
        #1 chk("R10", "sleep off", gate, 2'b00);
        nxt(); nxt(); slp = 1'b0;
        #1 chk("R10", "wake without edge", gate, 2'b11);
        nxt(); slp = 1'b1;
        #1 chk("R10", "sleep forces off", gate, 2'b00);
        nxt(); slp = 1'b0; latm = 1'b0;
        #1 chk("R10", "wake", gate, 2'b11);

        // Random phase against the model
        for (int k = 0; k < 4000; k++) begin
            nxt();
            for (int ch = 0; ch < 2; ch++) begin
                if ($urandom_range(0, 15) == 0) oc[ch] = ~oc[ch];
                if ($urandom_range(0, 23) == 0) ot[ch] = ~ot[ch];
                if ($urandom_range(0, 9) == 0) par[ch] = ~par[ch];
                if ($urandom_range(0, 9) == 0) ser[ch] = ~ser[ch];
                if ($urandom_range(0, 59) == 0) ilim[ch] = ~ilim[ch];
            end
            if ($urandom_range(0, 79) == 0) mode = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 149) == 0) latm = ~latm;
            slp = ($urandom_range(0, 96) == 0);
            #1 chk("R1", "random gate", gate, {mdl_gate(1), mdl_gate(0)});
            chk("R7", "random fault", flt, {m_flt[1], m_flt[0]});
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule